// File: doc/BRIEF.md
# Triggered multi-slice readout buffer

The block records a serial stream of sorted trigger objects, one time slice per bunch crossing, into a 512-entry circular buffer. A slice arrives as seven 32-bit words on consecutive cycles, and a sync pulse marks the first word. Each slice is packed into one 209-bit entry and written at the current write pointer. The pointer advances after every stored slice.

A trigger-accept pulse starts a readout. The readout copies one to three consecutive buffer entries into a de-randomising FIFO, and a downstream consumer drains that FIFO. The write pointer is preloaded with a latency value, which fixes how far behind the newest slice a readout starts. The FIFO has an almost-full flag with separate set and clear thresholds. A synchronous clear input empties the FIFO and returns the readout controller to idle.

Top module: `trig_slice_buf`

## Requirements
- R1: After reset the FIFO outputs are as follows: `fifo_empty`=1, `fifo_full`=0, `fifo_afull`=0, `fifo_count`=0 and `fifo_dv`=0.
- R2: A stored entry is laid out as follows:
  - bits 191:0 hold data word k at bits 32k+31:32k, for k = 0..5, where word 0 is the word presented with `obj_sync`;
  - bits 197:192 hold the per-word valid bits;
  - bits 201:198 hold the error bits;
  - bits 208:202 hold `bcn`, sampled in the sync cycle.
- R3: Word k sets valid bit 192+k when `obj_valid` is high in its cycle. A word without valid stores zero data. The seventh word of a slice is never stored.
- R4: If `obj_sync` arrives before the seventh word of a slice, the partial slice is still stored, with error bit 198 set and the missing words' valid bits clear. Error bits 201:200 are always zero.
- R5: When `lat_load` is high, `lat_val` is loaded into both the write pointer and the latency register. A trigger reads its first entry at address (write pointer − latency) mod 512. Further entries are read at incrementing addresses and enter the FIFO in address order.
- R6: The slice count is taken from `nslice`. A value of 0 reads one slice, values 1 to 3 read that many slices, and values 4 to 7 read three slices.
- R7: A trigger that arrives during a readout is held in a one-deep pending slot. The slot keeps the start address and count that apply at the moment of that trigger. The pending readout runs after the current one, and its entries carry error bit 199 set. Triggers that arrive while the slot is already occupied are discarded.
- R8: The FIFO is first-in first-out. A read with `fifo_rd` while the FIFO is not empty presents the entry on `fifo_dout` one cycle later, with `fifo_dv` high. A read of an empty FIFO leaves `fifo_dv` low and does not change `fifo_count`.
- R9: An entry offered to a full FIFO is discarded. `fifo_count` then stays at the depth and `fifo_full` stays high.
- R10: `fifo_afull` sets when the occupancy reaches `thr_set` or more. It then stays set until the occupancy falls to `thr_clr` or less.
- R11: `sw_clr` empties the FIFO, drops any readout in progress or pending, and returns the controller to idle. The buffer contents, the write pointer and the latency are kept.
- R12: `fsm_code` reads 8'h01 when the controller is idle and 8'h02 while it is issuing buffer reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clr | input | 1 | Synchronous clear of FIFO and controller |
| obj_word | input | 32 | Serial object word |
| obj_sync | input | 1 | Marks the first word of a slice |
| obj_valid | input | 1 | Qualifies the current object word |
| bcn | input | 7 | Crossing number, sampled with sync |
| trig | input | 1 | Trigger accept pulse |
| lat_load | input | 1 | Load the latency preload |
| lat_val | input | 9 | Latency preload value |
| nslice | input | 3 | Slices per trigger |
| thr_set | input | 9 | Almost-full set threshold |
| thr_clr | input | 9 | Almost-full clear threshold |
| fifo_rd | input | 1 | FIFO read request |
| fifo_dout | output | 209 | FIFO read data |
| fifo_dv | output | 1 | FIFO read data valid |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| fifo_afull | output | 1 | FIFO almost full, with hysteresis |
| fifo_count | output | 9 | FIFO occupancy |
| fsm_code | output | 8 | Readout controller state code |

## Verification
The bench targets the following corner cases, each of which a faulty design would get visibly wrong:
- **Slice packing.** A design that mis-orders word lanes or keeps the seventh word returns wrong entries when the bench sends slices with sparse valid patterns, including a slice whose only valid word is the seventh.
- **Early sync.** A short slice followed at once by a new sync exposes a design that drops the partial slice or forgets its error bit.
- **Trigger collisions.** Three triggers on consecutive cycles, each with a different count, show whether the pending slot keeps its own count and marks its entries, and whether the third trigger is discarded rather than queued.
- **Full FIFO and flag hysteresis.** Filling the FIFO past its depth catches overflow that wraps the count. Draining past the set threshold catches an almost-full flag that lacks hysteresis.
- **Mid-readout clear.** A clear in the middle of a readout catches reads that are still in flight and leak into the emptied FIFO.

// File: rtl/trig_slice_buf.sv
module trig_slice_buf #(
  parameter int WORD_W      = 32,
  parameter int SLICE_WORDS = 7,
  parameter int DATA_WORDS  = 6,
  parameter int BCN_W       = 7,
  parameter int ERR_W       = 4,
  parameter int ADDR_W      = 9,
  parameter int FIFO_AW     = 8,
  parameter int CNT_W       = 3,
  parameter int MAX_SLICES  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_clr,
  input  logic [WORD_W-1:0]        obj_word,
  input  logic                     obj_sync,
  input  logic                     obj_valid,
  input  logic [BCN_W-1:0]         bcn,
  input  logic                     trig,
  input  logic                     lat_load,
  input  logic [ADDR_W-1:0]        lat_val,
  input  logic [CNT_W-1:0]         nslice,
  input  logic [FIFO_AW:0]         thr_set,
  input  logic [FIFO_AW:0]         thr_clr,
  input  logic                     fifo_rd,
  output logic [BCN_W+ERR_W+DATA_WORDS+WORD_W*DATA_WORDS-1:0] fifo_dout,
  output logic                     fifo_dv,
  output logic                     fifo_empty,
  output logic                     fifo_full,
  output logic                     fifo_afull,
  output logic [FIFO_AW:0]         fifo_count,
  output logic [7:0]               fsm_code
);
  localparam int DATA_W  = WORD_W * DATA_WORDS;
  localparam int ERR_LO  = DATA_W + DATA_WORDS;
  localparam int SLICE_W = ERR_LO + ERR_W + BCN_W;
  localparam int IDX_W   = $clog2(SLICE_WORDS + 1);
  localparam int DEPTH   = 1 << FIFO_AW;
  localparam int OCC_W   = FIFO_AW + 1;
  localparam int BUF_N   = 1 << ADDR_W;

  typedef enum logic [7:0] {S_IDLE = 8'h01, S_READ = 8'h02} st_t;

  // slice collection
  logic              col;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_WORDS-1:0] acc_v;
  logic [BCN_W-1:0]  acc_bcn;

  wire [IDX_W-1:0] cur     = obj_sync ? '0 : idx;
  wire             take    = obj_sync | col;
  wire             wr_norm = col & ~obj_sync & (idx == IDX_W'(SLICE_WORDS - 1));
  wire             wr_short = col & obj_sync;
  wire             wr_slice = wr_norm | wr_short;
  wire [SLICE_W-1:0] wdata = {acc_bcn, {(ERR_W-1){1'b0}}, wr_short, acc_v, acc_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= 1'b0; idx <= '0; acc_d <= '0; acc_v <= '0; acc_bcn <= '0;
    end else if (take) begin
      if (obj_sync) begin
        acc_d <= '0; acc_v <= '0; acc_bcn <= bcn;
      end
      for (int k = 0; k < DATA_WORDS; k++)
        if (cur == IDX_W'(k)) begin
          acc_d[k*WORD_W +: WORD_W] <= obj_valid ? obj_word : '0;
          acc_v[k] <= obj_valid;
        end
      col <= (cur != IDX_W'(SLICE_WORDS - 1));
      idx <= IDX_W'(cur + 1'b1);
    end
  end

  // circular buffer write side
  logic [ADDR_W-1:0] wr_ptr, lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; lat <= '0;
    end else if (lat_load) begin
      wr_ptr <= lat_val; lat <= lat_val;
    end else if (wr_slice) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

  // readout controller
  st_t               st;
  logic [ADDR_W-1:0] raddr, pend_base;
  logic [CNT_W-1:0]  rem, pend_n;
  logic              rq, pend;

  function automatic logic [CNT_W-1:0] clamp_n(input logic [CNT_W-1:0] n);
    if (n == '0) return CNT_W'(1);
    if (n > CNT_W'(MAX_SLICES)) return CNT_W'(MAX_SLICES);
    return n;
  endfunction

  wire [ADDR_W-1:0] trig_base = wr_ptr - lat;
  wire              start     = (st == S_IDLE) & (trig | pend);
  wire              rd_issue  = (st == S_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_base <= '0; pend_n <= '0;
    end else if (sw_clr) begin
      pend <= 1'b0;
    end else if (st == S_IDLE) begin
      pend <= pend & trig;
      if (pend & trig) begin
        pend_base <= trig_base; pend_n <= clamp_n(nslice);
      end
    end else if (trig & ~pend) begin
      pend <= 1'b1; pend_base <= trig_base; pend_n <= clamp_n(nslice);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; raddr <= '0; rem <= '0; rq <= 1'b0;
    end else if (sw_clr) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_READ;
          raddr <= pend ? pend_base : trig_base;
          rem   <= (pend ? pend_n : clamp_n(nslice)) - 1'b1;
          rq    <= pend;
        end
        S_READ: if (rem == '0) st <= S_IDLE;
                else begin raddr <= raddr + 1'b1; rem <= rem - 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fsm_code = st;

  logic [SLICE_W-1:0] buf_mem [BUF_N];
  logic [SLICE_W-1:0] rdata;
  always_ff @(posedge clk) begin
    if (wr_slice) buf_mem[wr_ptr] <= wdata;
    if (rd_issue) rdata <= buf_mem[raddr];
  end

  logic push_v, push_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_v <= 1'b0; push_q <= 1'b0;
    end else begin
      push_v <= rd_issue & ~sw_clr;
      push_q <= rq;
    end
  end
  wire [SLICE_W-1:0] push_word = rdata | (SLICE_W'(push_q) << (ERR_LO + 1));

  // de-randomising FIFO
  logic [SLICE_W-1:0] fmem [DEPTH];
  logic [FIFO_AW-1:0] fw, fr;
  logic [OCC_W-1:0]   occ, occ_n;
  wire do_push = push_v & (occ != OCC_W'(DEPTH));
  wire do_pop  = fifo_rd & (occ != '0);
  assign occ_n = occ + OCC_W'(do_push) - OCC_W'(do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw <= '0; fr <= '0; occ <= '0; fifo_afull <= 1'b0; fifo_dv <= 1'b0;
    end else if (sw_clr) begin
      fw <= '0; fr <= '0; occ <= '0; fifo_afull <= 1'b0; fifo_dv <= 1'b0;
    end else begin
      if (do_push) fw <= fw + 1'b1;
      if (do_pop)  fr <= fr + 1'b1;
      occ     <= occ_n;
      fifo_dv <= do_pop;
      if (occ_n >= thr_set)      fifo_afull <= 1'b1;
      else if (occ_n <= thr_clr) fifo_afull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) fmem[fw] <= push_word;
    if (do_pop)  fifo_dout <= fmem[fr];
  end

  assign fifo_count = occ;
  assign fifo_empty = (occ == '0);
  assign fifo_full  = (occ == OCC_W'(DEPTH));

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= OCC_W'(DEPTH)); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !fifo_rd && !sw_clr |=> fifo_full); // R9
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> fifo_empty && fsm_code == 8'h01 && !fifo_dv); // R11
  AST_AF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_afull) |-> fifo_count >= thr_set); // R10
  AST_AF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_afull) |-> fifo_count <= thr_clr || $past(sw_clr)); // R10
  AST_FSM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fsm_code) == 1); // R12
  AST_DV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_dv |-> $past(fifo_rd) && !$past(fifo_empty)); // R8
endmodule

// File: tb/sim_trig_slice_buf.sv
module sim_trig_slice_buf;
  localparam int DEPTH = 8;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, sw_clr, obj_sync, obj_valid, trig, lat_load, fifo_rd;
  logic [31:0] obj_word;
  logic [6:0]  bcn;
  logic [8:0]  lat_val;
  logic [2:0]  nslice;
  logic [3:0]  thr_set, thr_clr;
  logic [208:0] fifo_dout;
  logic fifo_dv, fifo_empty, fifo_full, fifo_afull;
  logic [3:0] fifo_count;
  logic [7:0] fsm_code;

  trig_slice_buf #(.FIFO_AW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .obj_word(obj_word), .obj_sync(obj_sync),
    .obj_valid(obj_valid), .bcn(bcn), .trig(trig), .lat_load(lat_load), .lat_val(lat_val),
    .nslice(nslice), .thr_set(thr_set), .thr_clr(thr_clr), .fifo_rd(fifo_rd),
    .fifo_dout(fifo_dout), .fifo_dv(fifo_dv), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_afull(fifo_afull), .fifo_count(fifo_count), .fsm_code(fsm_code));

  int checks = 0, errs = 0;
  bit done = 0;
  logic [208:0] mdl_mem [512];
  logic [8:0]   mwp, mlat;
  logic [208:0] expq [$];

  task automatic chk(input string tag, input logic [208:0] act, input logic [208:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [208:0] pack(input logic [6:0] b, input logic e0, input logic e1,
                                        input logic [5:0] v, input logic [191:0] d);
    return {b, 2'b00, e1, e0, v, d};
  endfunction

  function automatic int clampn(input int n);
    if (n == 0) return 1;
    if (n > 3) return 3;
    return n;
  endfunction

  task automatic exp_push(input logic [208:0] w);
    if (expq.size() < DEPTH) expq.push_back(w);
  endtask

  task automatic send_slice(input logic [6:0] b, input logic [6:0] vm, input int nw, input logic [7:0] seed);
    logic [191:0] d = '0;
    logic [5:0]   v = '0;
    for (int k = 0; k < nw; k++) begin
      obj_sync  = (k == 0);
      obj_valid = vm[k];
      bcn       = b;
      obj_word  = {seed, 8'(k), seed ^ 8'hA5, 8'(k * 3 + 1)};
      if (k < 6 && vm[k]) begin
        d[k*32 +: 32] = obj_word;
        v[k] = 1'b1;
      end
      @(negedge clk);
    end
    obj_sync = 0; obj_valid = 0; obj_word = '0;
    mdl_mem[mwp] = pack(b, nw < 7, 1'b0, v, d);
    mwp = mwp + 1'b1;
  endtask

  task automatic fire(input int n, input string tag);
    logic [8:0] base;
    nslice = 3'(n); trig = 1;
    @(negedge clk);
    trig = 0;
    chk({tag, " R12 fsm reading"}, 209'(fsm_code), 209'(8'h02));
    base = mwp - mlat;
    for (int i = 0; i < clampn(n); i++) exp_push(mdl_mem[9'(base + 9'(i))]);
  endtask

  task automatic pop_chk(input string tag);
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
    chk({tag, " dv"}, 209'(fifo_dv), 209'(1));
    chk(tag, fifo_dout, expq.pop_front());
  endtask

  task automatic drain(input string tag);
    while (expq.size() > 0) pop_chk(tag);
    chk({tag, " R8 empty after drain"}, 209'(fifo_empty), 209'(1));
  endtask

  task automatic t_reset;
    chk("R1 empty", 209'(fifo_empty), 209'(1));
    chk("R1 full", 209'(fifo_full), 209'(0));
    chk("R1 afull", 209'(fifo_afull), 209'(0));
    chk("R1 count", 209'(fifo_count), 209'(0));
    chk("R1 dv", 209'(fifo_dv), 209'(0));
    chk("R12 fsm idle", 209'(fsm_code), 209'(8'h01));
  endtask

  task automatic t_pack;
    send_slice(7'h11, 7'h7F, 7, 8'h10);
    send_slice(7'h22, 7'h3F, 7, 8'h20);
    send_slice(7'h33, 7'h15, 7, 8'h30);
    cyc(2);
    send_slice(7'h44, 7'h40, 7, 8'h40);
    send_slice(7'h55, 7'h2A, 7, 8'h50);
    cyc(2);
    fire(1, "R5 single");
    cyc(8);
    chk("R5 one entry", 209'(fifo_count), 209'(1));
    drain("R2/R3 packed slice");
    fire(3, "R5 triple");
    cyc(8);
    chk("R5 three entries", 209'(fifo_count), 209'(3));
    drain("R5 address order R2 R3");
  endtask

  task automatic t_clamp;
    fire(0, "R6 zero");
    cyc(8);
    chk("R6 count zero reads one", 209'(fifo_count), 209'(1));
    drain("R6 zero data");
    fire(7, "R6 seven");
    cyc(10);
    chk("R6 count seven reads three", 209'(fifo_count), 209'(3));
    drain("R6 seven data");
  endtask

  task automatic t_incomplete;
    logic [208:0] w;
    send_slice(7'h66, 7'h7F, 4, 8'h60);
    send_slice(7'h77, 7'h7B, 7, 8'h70);
    send_slice(7'h08, 7'h5C, 7, 8'h80);
    cyc(2);
    w = mdl_mem[9'(mwp - 9'd3)];
    fire(3, "R4");
    cyc(10);
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
    chk("R4 short slice entry", fifo_dout, w);
    chk("R4 error bit 198", 209'(fifo_dout[198]), 209'(1));
    chk("R4 valid bits", 209'(fifo_dout[197:192]), 209'(6'h0F));
    void'(expq.pop_front());
    drain("R4 following slices");
  endtask

  task automatic t_queue;
    logic [8:0] base;
    logic [208:0] w;
    base = mwp - mlat;
    nslice = 3; trig = 1;
    @(negedge clk);
    nslice = 2;
    @(negedge clk);
    nslice = 1;
    @(negedge clk);
    trig = 0;
    for (int i = 0; i < 3; i++) exp_push(mdl_mem[9'(base + 9'(i))]);
    for (int i = 0; i < 2; i++) begin
      w = mdl_mem[9'(base + 9'(i))];
      w[199] = 1'b1;
      exp_push(w);
    end
    cyc(12);
    chk("R7 queued count, third trigger dropped", 209'(fifo_count), 209'(5));
    drain("R7 queued entries");
  endtask

  task automatic t_empty_read;
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
    chk("R8 empty read dv", 209'(fifo_dv), 209'(0));
    chk("R8 empty read count", 209'(fifo_count), 209'(0));
  endtask

  task automatic t_full;
    fire(3, "R10 fill1");
    cyc(8);
    chk("R10 count 3", 209'(fifo_count), 209'(3));
    chk("R10 afull low below set", 209'(fifo_afull), 209'(0));
    fire(3, "R10 fill2");
    cyc(8);
    chk("R10 afull set at 6", 209'(fifo_afull), 209'(1));
    fire(3, "R9 overfill");
    cyc(8);
    chk("R9 count saturates", 209'(fifo_count), 209'(DEPTH));
    chk("R9 full", 209'(fifo_full), 209'(1));
    for (int i = 0; i < 5; i++) pop_chk("R9 order after overflow");
    chk("R10 count 3 on drain", 209'(fifo_count), 209'(3));
    chk("R10 afull held above clear", 209'(fifo_afull), 209'(1));
    pop_chk("R9 order after overflow");
    chk("R10 afull cleared at 2", 209'(fifo_afull), 209'(0));
    drain("R9 tail");
  endtask

  task automatic t_swclr;
    fire(1, "R11 preload");
    cyc(8);
    chk("R11 one entry before clear", 209'(fifo_count), 209'(1));
    fire(3, "R11 start");
    sw_clr = 1; trig = 1;
    @(negedge clk);
    sw_clr = 0; trig = 0;
    expq.delete();
    cyc(8);
    chk("R11 count after clear", 209'(fifo_count), 209'(0));
    chk("R11 empty after clear", 209'(fifo_empty), 209'(1));
    chk("R11 fsm idle after clear", 209'(fsm_code), 209'(8'h01));
    fire(2, "R11 buffer kept");
    cyc(8);
    drain("R11 buffer kept");
  endtask

  initial begin
    rst_n = 0; sw_clr = 0; obj_sync = 0; obj_valid = 0; trig = 0; lat_load = 0; fifo_rd = 0;
    obj_word = '0; bcn = '0; lat_val = '0; nslice = 3'd1; thr_set = 4'd6; thr_clr = 4'd2;
    mwp = '0; mlat = '0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    lat_load = 1; lat_val = 9'd3;
    @(negedge clk);
    lat_load = 0;
    mwp = 9'd3; mlat = 9'd3;
    t_pack();
    t_clamp();
    t_incomplete();
    t_queue();
    t_empty_read();
    t_full();
    t_swclr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule